// File: doc/BRIEF.md
# Three-Requester Round-Robin Bus Arbiter

This block chooses which of three bus devices, called A, B and C, owns a shared bus in each clock cycle. Each device raises a single request line. On every rising clock edge the arbiter registers a 2-bit binary code that names the chosen device. It is a polling arbiter, so the code always names exactly one device. When nobody asks for the bus, device A is named.

When two or three devices request in the same cycle, the winner depends on the device the registered code named before the edge. The search starts at the device after that one and wraps around, so a device that was just served drops to the lowest priority. An idle cycle also counts, as a grant to A. The block has no handshake and no hold: each edge recomputes the code from the request lines present at that edge.

Top module: `rrarb_top`

## Requirements
- R1: An active-high reset drives `grant_o` to 2'b00 (device A) at once, without waiting for a clock edge, and holds it there while reset stays high.
- R2: The grant codes are 2'b00 for A, 2'b01 for B and 2'b10 for C. The code 2'b11 never appears on `grant_o`.
- R3: If no request is high at a rising edge, `grant_o` becomes 2'b00 after that edge.
- R4: If exactly one request is high at a rising edge, `grant_o` names that device after the edge, whatever the code was before.
- R5: With two or more requests and a current code naming A, the first requesting device in the order B, C, A wins.
- R6: With two or more requests and a current code naming B, the first requesting device in the order C, A, B wins.
- R7: With two or more requests and a current code naming C, the first requesting device in the order A, B, C wins.
- R8: The last grant used for rotation is the registered output itself. An idle cycle that yields A therefore leads to the B, C, A order on the next contended edge.
- R9: The code is recomputed at every edge from the requests at that edge. A device is never kept once its request drops while another device requests.
- R10: A device whose request stays high is named within three consecutive edges.
- R11: Whenever at least one request is high at an edge, the device named after that edge was requesting at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| req_a_i | input | 1 | Bus request from device A |
| req_b_i | input | 1 | Bus request from device B |
| req_c_i | input | 1 | Bus request from device C |
| grant_o | output | 2 | Registered grant code: 00 = A, 01 = B, 10 = C |

## Verification
The only state is the grant register, and it is also the output. A wrong stored value therefore shows at the ports straight away, and it changes the rotation order on the very next contended edge. The bench puts the register into each legal value by driving a single request. It then applies all eight request patterns and compares the code one edge later against an arithmetic rotation model. A long random run checks fairness: any device that keeps requesting through three edges without being named exposes a rotation fault within those three edges.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;
   localparam int unsigned RR_NUM_DEV = 3;
   localparam int unsigned RR_CODE_W  = 2;

   typedef logic [RR_CODE_W-1:0] rr_code_t;

   localparam rr_code_t RR_DEV_A = 2'd0;
   localparam rr_code_t RR_DEV_B = 2'd1;
   localparam rr_code_t RR_DEV_C = 2'd2;
endpackage

// File: rtl/rrarb_rotate.sv
// Turns the stored grant code into a search start point and rotates the
// request vector so that bit 0 is the first device to search.
module rrarb_rotate #(
   parameter int unsigned NUM = 3,
   parameter int unsigned W   = 2
) (
   input  logic [NUM-1:0] req,
   input  logic [W-1:0]   last,
   output logic [W-1:0]   start,
   output logic [NUM-1:0] rot
);
   generate
      if (NUM < 2) begin : g_bad_num
         $error("rrarb_rotate: NUM must be at least 2");
      end
      if ((1 << W) < NUM) begin : g_bad_w
         $error("rrarb_rotate: W too narrow for NUM");
      end
   endgenerate

   // A last code at or beyond the final device (including unused codes)
   // wraps the search back to device 0.
   always_comb begin
      if (int'(last) >= int'(NUM) - 1) start = '0;
      else                             start = last + W'(1);
   end

   int idx;
   always_comb begin
      rot = '0;
      idx = 0;
      for (int k = 0; k < int'(NUM); k++) begin
         idx = int'(start) + k;
         if (idx >= int'(NUM)) idx = idx - int'(NUM);
         rot[k] = req[idx];
      end
   end
endmodule

// File: rtl/rrarb_pick.sv
// Finds the first set bit of the rotated vector and maps it back to a device.
module rrarb_pick #(
   parameter int unsigned NUM      = 3,
   parameter int unsigned W        = 2,
   parameter int unsigned IDLE_IDX = 0
) (
   input  logic [NUM-1:0] rot,
   input  logic [W-1:0]   start,
   output logic [W-1:0]   pick
);
   generate
      if (IDLE_IDX >= NUM) begin : g_bad_idle
         $error("rrarb_pick: IDLE_IDX out of range");
      end
   endgenerate

   int  off;
   int  sum;
   logic found;

   always_comb begin
      off   = 0;
      found = 1'b0;
      for (int k = int'(NUM) - 1; k >= 0; k--) begin
         if (rot[k]) begin
            off   = k;
            found = 1'b1;
         end
      end
      sum = int'(start) + off;
      if (sum >= int'(NUM)) sum = sum - int'(NUM);
      pick = found ? W'(sum) : W'(IDLE_IDX);
   end
endmodule

// File: rtl/rrarb_hold.sv
// Grant register with asynchronous reset; its value is also the last grant.
module rrarb_hold #(
   parameter int unsigned W       = 2,
   parameter int unsigned RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) q <= W'(RST_VAL);
      else     q <= d;
   end
endmodule

// File: rtl/rrarb_top.sv
module rrarb_top
   import rrarb_pkg::*;
(
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           req_a_i,
   input  logic           req_b_i,
   input  logic           req_c_i,
   output logic [1:0]     grant_o
);
   localparam int unsigned NUM = RR_NUM_DEV;
   localparam int unsigned W   = RR_CODE_W;

   logic [NUM-1:0] req_vec;
   logic [W-1:0]   start_idx;
   logic [NUM-1:0] rot_vec;
   logic [W-1:0]   next_code;
   rr_code_t       cur_code;

   assign req_vec = {req_c_i, req_b_i, req_a_i};

   rrarb_rotate #(.NUM(NUM), .W(W)) u_rotate (
      .req   (req_vec),
      .last  (cur_code),
      .start (start_idx),
      .rot   (rot_vec)
   );

   rrarb_pick #(.NUM(NUM), .W(W), .IDLE_IDX(int'(RR_DEV_A))) u_pick (
      .rot   (rot_vec),
      .start (start_idx),
      .pick  (next_code)
   );

   rrarb_hold #(.W(W), .RST_VAL(int'(RR_DEV_A))) u_hold (
      .clk (clk_i),
      .rst (rst_i),
      .d   (next_code),
      .q   (cur_code)
   );

   assign grant_o = cur_code;
endmodule

// File: rtl/rrarb_chk.sv
module rrarb_chk (
   input logic       clk,
   input logic       rst,
   input logic [2:0] req,
   input logic [1:0] grant
);
   // R1
   always @(posedge clk) begin
      if (rst) rst_grant_chk: assert (grant == 2'b00);
   end

   // R2
   never_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
      grant != 2'b11);

   // R3
   idle_to_a_chk: assert property (@(posedge clk) disable iff (rst)
      (req == 3'b000) |=> (grant == 2'b00));

   // R4
   only_b_chk: assert property (@(posedge clk) disable iff (rst)
      (req == 3'b010) |=> (grant == 2'b01));

   // R4
   only_c_chk: assert property (@(posedge clk) disable iff (rst)
      (req == 3'b100) |=> (grant == 2'b10));

   // R5
   after_a_chk: assert property (@(posedge clk) disable iff (rst)
      (grant == 2'b00 && req[1]) |=> (grant == 2'b01));

   // R6
   after_b_chk: assert property (@(posedge clk) disable iff (rst)
      (grant == 2'b01 && req[2]) |=> (grant == 2'b10));

   // R7
   after_c_chk: assert property (@(posedge clk) disable iff (rst)
      (grant == 2'b10 && req[0]) |=> (grant == 2'b00));

   // R11
   winner_requested_chk: assert property (@(posedge clk) disable iff (rst)
      (req != 3'b000) |=> (($past(req) & (3'b001 << grant)) != 3'b000));
endmodule

bind rrarb_top rrarb_chk u_chk (
   .clk   (clk_i),
   .rst   (rst_i),
   .req   ({req_c_i, req_b_i, req_a_i}),
   .grant (grant_o)
);

// File: tb/rrarb_top_test.sv
`timescale 1ns/1ps
module rrarb_top_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] req = 3'b000;
   logic [1:0] grant;
   int         n_chk = 0;
   int         n_bad = 0;
   logic [1:0] last = 2'b00;
   int         wait_cnt [3];

   always #2.5 clk = ~clk;

   rrarb_top uut (
      .clk_i   (clk),
      .rst_i   (rst),
      .req_a_i (req[0]),
      .req_b_i (req[1]),
      .req_c_i (req[2]),
      .grant_o (grant)
   );

   function automatic logic [1:0] model(input logic [2:0] r, input logic [1:0] l);
      int s;
      int d;
      if (r == 3'b000) return 2'b00;
      s = (int'(l) >= 2) ? 0 : int'(l) + 1;
      for (int k = 0; k < 3; k++) begin
         d = (s + k) % 3;
         if (r[d]) return 2'(d);
      end
      return 2'b00;
   endfunction

   function automatic string tag_of(input logic [2:0] r, input logic [1:0] l);
      if (r == 3'b000) return "R3";
      if ($countones(r) == 1) return "R4";
      if (l == 2'b00) return "R5";
      if (l == 2'b01) return "R6";
      return "R7";
   endfunction

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
      end
   endtask

   // Drive req on a falling edge, sample 1 ns after the next rising edge.
   task automatic step(input logic [2:0] r, input string tag);
      logic [1:0] e;
      @(negedge clk);
      req = r;
      e = model(r, last);
      @(posedge clk);
      #1;
      check(tag, grant, e);
      if (grant == 2'b11) check("R2", grant, 2'b00);
      last = e;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: grant=%b expected=done", grant);
      finish_run();
   end

   initial begin
      #1;
      check("R1", grant, 2'b00);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      last = 2'b00;

      // r2_ r5 r6 r7 r3 r4: every pattern after every legal last grant
      for (int l = 0; l < 3; l++) begin
         for (int r = 0; r < 8; r++) begin
            step(3'(1 << l), "R4");
            step(3'(r), tag_of(3'(r), 2'(l)));
         end
      end

      // R8: idle leaves A as last grant, so B before C, then C before A
      step(3'b000, "R3");
      step(3'b110, "R8");
      step(3'b000, "R3");
      step(3'b101, "R8");

      // R9: no hold once the request drops
      step(3'b100, "R9");
      step(3'b011, "R9");
      step(3'b001, "R9");
      step(3'b010, "R9");

      // R1: asynchronous reset mid-cycle from a C grant
      step(3'b100, "R4");
      @(negedge clk);
      rst = 1'b1;
      #1;
      check("R1", grant, 2'b00);
      @(posedge clk);
      #1;
      check("R1", grant, 2'b00);
      @(negedge clk);
      rst = 1'b0;
      req = 3'b000;
      last = 2'b00;

      // R10 R11: random traffic with a fairness counter per device
      for (int d = 0; d < 3; d++) wait_cnt[d] = 0;
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] r;
         r = 3'($urandom_range(0, 7));
         if (i % 50 < 20) r = r | 3'b111;
         step(r, tag_of(r, last));
         if (r != 3'b000) begin
            n_chk++;
            if (!r[grant]) begin
               n_bad++;
               $display("FAIL R11: grant=%b expected a requester of %b", grant, r);
            end
         end
         for (int d = 0; d < 3; d++) begin
            if (r[d] && grant != 2'(d)) wait_cnt[d]++;
            else                        wait_cnt[d] = 0;
            n_chk++;
            if (wait_cnt[d] > 2) begin
               n_bad++;
               $display("FAIL R10: device %0d waited=%0d expected<=2", d, wait_cnt[d]);
            end
         end
      end

      finish_run();
   end
endmodule